// File: doc/BRIEF.md
# Presettable Synchronous Binary Counter

A binary up-counter slice of parameterised width (four bits by default) that advances on the rising clock edge. The slice can be cleared to zero or forced to a preset word in a single cycle. It is built to be chained into wider counters.

Counting needs two enables. The first enable, `cnt_en`, is shared by every slice of a chain. The second enable, `carry_en`, also gates the terminal-count output. In a chain, each slice's `term_cnt` drives the `carry_en` of the next slice. Carry lookahead therefore stays a single AND per slice, and all slices can still be paused together through `cnt_en`. Neither enable has any effect on a load.

Top module: `sync_preset_counter`

## Requirements
- R1: At a rising clock edge with `clr_n` high, `load_n` high, `cnt_en` high and `carry_en` high, `count` increases by one.
- R2: At a rising clock edge with `clr_n` low, `count` becomes zero. This takes priority over load and count.
- R3: At a rising clock edge with `clr_n` high and `load_n` low, `count` takes the value of `preset`, whatever the levels of `cnt_en` and `carry_en`.
- R4: At a rising clock edge with `clr_n` high, `load_n` high and either enable low, `count` keeps its value.
- R5: A counting edge taken at the all-ones value (15 for the default width) returns `count` to zero.
- R6: `term_cnt` is combinational. It is high exactly when `carry_en` is high and `count` is all ones, whatever the level of `cnt_en`.
- R7: While `carry_en` is low, `term_cnt` is low for every value of `count`.
- R8: Three slices chained as described, with the first slice's `carry_en` tied high, form a 12-bit counter. This counter steps from 0 through 4095 and wraps to 0, and it holds while the shared `cnt_en` is low.
- R9: A load requested while `count` is all ones and both enables are high loads `preset` instead of wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| clr_n | input | 1 | Synchronous clear, active low, highest priority |
| load_n | input | 1 | Synchronous parallel load, active low |
| preset | input | WIDTH | Word loaded when `load_n` is low |
| cnt_en | input | 1 | Count enable shared across a chain |
| carry_en | input | 1 | Count enable that also gates `term_cnt` |
| count | output | WIDTH | Registered count value |
| term_cnt | output | 1 | Carry out: `carry_en` AND count all ones |

## Verification
Two functions can meet in one cycle: a load and the wrap from all ones. The bench brings one slice to 15 with both enables high and lowers `load_n` on that same edge. It then expects the preset word, not zero. Clear and load also meet: the bench asserts both on one edge with the enables high and expects zero. All other cycles are judged against an arithmetic model that applies the priority clear > load > count > hold. The model runs over every preset value, each enable combination and a long random stretch.

// File: rtl/spc_pkg.sv
package spc_pkg;

  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_COUNT = 2'd1,
    OP_LOAD  = 2'd2,
    OP_CLEAR = 2'd3
  } spc_op_e;

endpackage

// File: rtl/spc_decode.sv
module spc_decode
  import spc_pkg::*;
(
  input  logic    clr_n,
  input  logic    load_n,
  input  logic    cnt_en,
  input  logic    carry_en,
  output spc_op_e op
);

  // Priority: clear, then load, then count; anything else holds.
  always_comb begin
    if (!clr_n) begin
      op = OP_CLEAR;
    end else if (!load_n) begin
      op = OP_LOAD;
    end else if (cnt_en && carry_en) begin
      op = OP_COUNT;
    end else begin
      op = OP_HOLD;
    end
  end

endmodule

// File: rtl/spc_state.sv
module spc_state
  import spc_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  spc_op_e          op,
  input  logic [WIDTH-1:0] preset,
  output logic [WIDTH-1:0] q
);

  localparam logic [WIDTH-1:0] STEP = WIDTH'(1);

  always_ff @(posedge clk) begin
    case (op)
      OP_CLEAR: q <= '0;
      OP_LOAD:  q <= preset;
      OP_COUNT: q <= q + STEP;
      default:  q <= q;
    endcase
  end

  AST_CLEAR_RESULT: assert property (@(posedge clk) (op == OP_CLEAR) |=> (q == '0)); // R2

endmodule

// File: rtl/spc_carry.sv
module spc_carry #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] q,
  input  logic             carry_en,
  output logic             tc
);

  assign tc = carry_en & (&q);

endmodule

// File: rtl/sync_preset_counter.sv
module sync_preset_counter
  import spc_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             clr_n,
  input  logic             load_n,
  input  logic [WIDTH-1:0] preset,
  input  logic             cnt_en,
  input  logic             carry_en,
  output logic [WIDTH-1:0] count,
  output logic             term_cnt
);

  localparam logic [WIDTH-1:0] STEP = WIDTH'(1);

  spc_op_e op;

  spc_decode u_decode (
    .clr_n    (clr_n),
    .load_n   (load_n),
    .cnt_en   (cnt_en),
    .carry_en (carry_en),
    .op       (op)
  );

  spc_state #(.WIDTH(WIDTH)) u_state (
    .clk    (clk),
    .op     (op),
    .preset (preset),
    .q      (count)
  );

  spc_carry #(.WIDTH(WIDTH)) u_carry (
    .q        (count),
    .carry_en (carry_en),
    .tc       (term_cnt)
  );

  AST_CLEAR_WINS: assert property (@(posedge clk) !clr_n |=> (count == '0)); // R2

  AST_LOAD_PRESET: assert property (@(posedge clk) disable iff (!clr_n)
    !load_n |=> (count == $past(preset))); // R3

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!clr_n)
    (load_n && cnt_en && carry_en) |=> (count == $past(count) + STEP)); // R1

  AST_HOLD_VALUE: assert property (@(posedge clk) disable iff (!clr_n)
    (load_n && !(cnt_en && carry_en)) |=> $stable(count)); // R4

  AST_TC_GATED: assert property (@(posedge clk) disable iff (!clr_n)
    !carry_en |-> !term_cnt); // R7

  AST_TC_AT_FULL: assert property (@(posedge clk) disable iff (!clr_n)
    (carry_en && (count == '1)) |-> term_cnt); // R6

endmodule

// File: tb/sync_preset_counter_bench.sv
module sync_preset_counter_bench;

  localparam int CLK_PERIOD = 10;
  localparam int W = 4;
  localparam int STAGES = 3;

  logic clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic         clr_n = 1'b0;
  logic         load_n = 1'b1;
  logic [W-1:0] preset = '0;
  logic         cnt_en = 1'b0;
  logic         carry_en = 1'b0;
  logic [W-1:0] count;
  logic         term_cnt;

  int tests = 0;
  int fails = 0;
  int exp_val = 0;

  sync_preset_counter #(.WIDTH(W)) u_sync_preset_counter (
    .clk      (clk),
    .clr_n    (clr_n),
    .load_n   (load_n),
    .preset   (preset),
    .cnt_en   (cnt_en),
    .carry_en (carry_en),
    .count    (count),
    .term_cnt (term_cnt)
  );

  // Three-slice chain for R8
  logic                 c_clr_n = 1'b0;
  logic                 c_en = 1'b0;
  logic [STAGES-1:0]    c_tc;
  logic [STAGES-1:0]    c_carry;
  logic [W*STAGES-1:0]  c_val;
  int                   c_exp = 0;

  assign c_carry = {c_tc[STAGES-2:0], 1'b1};

  for (genvar g = 0; g < STAGES; g++) begin : g_chain
    sync_preset_counter #(.WIDTH(W)) u_slice (
      .clk      (clk),
      .clr_n    (c_clr_n),
      .load_n   (1'b1),
      .preset   ('0),
      .cnt_en   (c_en),
      .carry_en (c_carry[g]),
      .count    (c_val[g*W +: W]),
      .term_cnt (c_tc[g])
    );
  end

  task automatic check(input string req, input int act, input int expv);
    tests++;
    if (act != expv) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  // One edge of the single slice: model update, then compare at the negedge.
  task automatic tick();
    string tag;
    if (!clr_n) begin
      tag = "R2"; exp_val = 0;
    end else if (!load_n) begin
      tag = (exp_val == 15 && cnt_en && carry_en) ? "R9" : "R3";
      exp_val = int'(preset);
    end else if (cnt_en && carry_en) begin
      tag = (exp_val == 15) ? "R5" : "R1";
      exp_val = (exp_val + 1) % 16;
    end else begin
      tag = "R4";
    end
    @(posedge clk);
    @(negedge clk);
    check(tag, int'(count), exp_val);
    check(carry_en ? "R6" : "R7", int'(term_cnt),
          (carry_en && exp_val == 15) ? 1 : 0);
  endtask

  task automatic drive(input logic c, input logic l, input int p,
                       input logic e1, input logic e2);
    clr_n = c; load_n = l; preset = W'(p); cnt_en = e1; carry_en = e2;
  endtask

  task automatic ctick();
    if (!c_clr_n) c_exp = 0;
    else if (c_en) c_exp = (c_exp + 1) % 4096;
    @(posedge clk);
    @(negedge clk);
    check("R8", int'(c_val), c_exp);
  endtask

  initial begin
    @(negedge clk);
    drive(1'b0, 1'b1, 0, 1'b1, 1'b1);
    tick(); // reset state, R2

    // Every preset, every enable combination
    for (int p = 0; p < 16; p++) begin
      drive(1'b1, 1'b0, p, 1'b0, 1'b0); tick();        // R3 with enables low
      drive(1'b1, 1'b1, 0, 1'b1, 1'b0); tick(); tick(); // R4
      drive(1'b1, 1'b1, 0, 1'b0, 1'b1); tick(); tick(); // R4, R6 with cnt_en low
      drive(1'b1, 1'b1, 0, 1'b1, 1'b1);
      for (int k = 0; k < 18; k++) tick();              // R1, R5
    end

    // Clear together with load and enables: clear wins (R2)
    drive(1'b1, 1'b0, 9, 1'b1, 1'b1); tick();
    drive(1'b0, 1'b0, 5, 1'b1, 1'b1); tick();

    // Load on the wrapping edge (R9)
    drive(1'b1, 1'b0, 15, 1'b0, 1'b0); tick();
    drive(1'b1, 1'b0, 6, 1'b1, 1'b1); tick();
    check("R9", int'(count), 6);

    // Terminal count ignores cnt_en (R6), forced low by carry_en (R7)
    drive(1'b1, 1'b0, 15, 1'b0, 1'b0); tick();
    drive(1'b1, 1'b1, 0, 1'b0, 1'b1); #1;
    check("R6", int'(term_cnt), 1);
    carry_en = 1'b0; #1;
    check("R7", int'(term_cnt), 0);

    // Random stretch
    for (int i = 0; i < 3000; i++) begin
      drive(($urandom % 32) != 0, ($urandom % 6) != 0, int'($urandom % 16),
            ($urandom % 4) != 0, ($urandom % 4) != 0);
      tick();
    end

    // Chain: clear, full cycle with wrap, pause, more counting (R8)
    c_clr_n = 1'b0; c_en = 1'b1; ctick();
    c_clr_n = 1'b1;
    for (int i = 0; i < 4100; i++) ctick();
    c_en = 1'b0;
    for (int i = 0; i < 5; i++) ctick();
    c_en = 1'b1;
    for (int i = 0; i < 20; i++) ctick();

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    tests++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule